// File: doc/BRIEF.md
# Exponent Rebias Stage for Unmasked Overflow and Underflow

This stage runs after the rounder of an extended-precision datapath. It takes a rounded result whose exponent may lie outside the 15-bit biased exponent field. That result comes with a sign, an unbounded signed biased exponent, a 64-bit significand with an explicit integer bit, and a flag that says whether rounding moved the significand upward. Strobes mark an unmasked overflow, an unmasked underflow, and whether the destination is memory rather than a register.

For a register destination, the stage moves the exponent back toward the middle of the legal range by a fixed offset of 24576. It subtracts the offset on overflow and adds it on underflow, so that a scaled computation can continue. If the moved exponent still does not fit in the range of normal numbers, the stage saturates. On overflow it writes an infinity with the result's sign, and on underflow it writes a zero with the result's sign. For a memory destination with an unmasked exception, it suppresses the write entirely. Every output is registered and appears one cycle after the input strobe.

Top module: `rebias_unit`

## Requirements
- R1: On an overflow strobe with a register destination, when `in_exp - 24576` lies in 1..0x7FFE, the output exponent equals that value. The sign and the significand pass through unchanged, and `out_store` is 1.
- R2: On an underflow strobe with a register destination, when `in_exp + 24576` lies in 1..0x7FFE, the output exponent equals that value. The sign and the significand pass through unchanged, and `out_store` is 1.
- R3: On an overflow strobe with a register destination, when `in_exp - 24576` exceeds 0x7FFE, the output is an infinity that keeps the input sign: exponent 0x7FFF, significand 0x8000_0000_0000_0000, and `out_store` is 1.
- R4: On an underflow strobe with a register destination, when `in_exp + 24576` is below 1, the output is a zero that keeps the input sign: exponent 0, significand 0, and `out_store` is 1.
- R5: For a register destination, `out_c1` equals `in_round_up`.
- R6: When either exception strobe is set and `in_dest_mem` is 1, `out_store` is 0 and `out_c1` is 0.
- R7: With neither exception strobe set, the low 15 bits of the exponent, the significand and the sign pass through unchanged, and `out_store` is 1.
- R8: When both exception strobes are set, the overflow strobe takes priority.
- R9: `out_valid` rises exactly one cycle after `in_valid`. In a cycle without `in_valid`, the next edge clears `out_valid` and `out_store` and holds every result field.
- R10: While `rst` is high, every output register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result strobe |
| in_sign | input | 1 | Result sign |
| in_exp | input | 18 | Unbounded biased exponent, two's complement |
| in_sig | input | 64 | Rounded significand with explicit integer bit |
| in_round_up | input | 1 | Rounding moved the significand away from zero |
| in_ovf | input | 1 | Unmasked overflow |
| in_unf | input | 1 | Unmasked underflow |
| in_dest_mem | input | 1 | Destination is memory (1) or a register (0) |
| out_valid | output | 1 | Output strobe |
| out_store | output | 1 | Write enable for the destination register |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Biased exponent field |
| out_sig | output | 64 | Significand |
| out_c1 | output | 1 | Round-up status bit |

## Verification
The bench builds the stage with its default parameters: an 18-bit unbounded exponent, a 15-bit field, a 64-bit significand and an offset of 24576. With these values the exact edges of both wrapped windows are reachable as plain inputs: 57342 maps to 0x7FFE and 57343 saturates to infinity, while -24575 maps to 1 and -24576 collapses to zero. Both signs, the strobe priority, the memory suppression and hold-while-idle are driven as separate scenarios.

// File: rtl/rebias_pkg.sv
package rebias_pkg;

    localparam int EXP_W_DEF     = 18;
    localparam int FIELD_W_DEF   = 15;
    localparam int SIG_W_DEF     = 64;
    localparam int WRAP_BIAS_DEF = 24576;

    // Outcome chosen by the classifier for one result.
    typedef enum logic [2:0] {
        K_PASS     = 3'd0,
        K_WRAP_DN  = 3'd1,
        K_WRAP_UP  = 3'd2,
        K_SAT_INF  = 3'd3,
        K_SAT_ZERO = 3'd4,
        K_SUPPRESS = 3'd5
    } fix_kind_e;

    function automatic logic kind_writes(fix_kind_e k);
        return k != K_SUPPRESS;
    endfunction

    function automatic logic kind_keeps_sig(fix_kind_e k);
        return (k == K_PASS) || (k == K_WRAP_DN) || (k == K_WRAP_UP);
    endfunction

endpackage

// File: rtl/rebias_classify.sv
module rebias_classify
    import rebias_pkg::*;
#(
    parameter int EXP_W     = EXP_W_DEF,
    parameter int FIELD_W   = FIELD_W_DEF,
    parameter int WRAP_BIAS = WRAP_BIAS_DEF
) (
    input  logic                      ovf,
    input  logic                      unf,
    input  logic                      dest_mem,
    input  logic signed [EXP_W-1:0]   exp_in,
    output fix_kind_e                 kind,
    output logic [FIELD_W-1:0]        exp_field
);
    localparam logic signed [EXP_W-1:0] BIAS_S   = EXP_W'(WRAP_BIAS);
    localparam logic signed [EXP_W-1:0] MAX_NORM = EXP_W'((1 << FIELD_W) - 2);
    localparam logic signed [EXP_W-1:0] MIN_NORM = EXP_W'(1);

    logic signed [EXP_W-1:0] adj;

    // Overflow wins when both strobes are present.
    always_comb begin
        if (ovf)      adj = exp_in - BIAS_S;
        else if (unf) adj = exp_in + BIAS_S;
        else          adj = exp_in;
    end

    always_comb begin
        if ((ovf || unf) && dest_mem)  kind = K_SUPPRESS;
        else if (ovf)                  kind = (adj > MAX_NORM) ? K_SAT_INF  : K_WRAP_DN;
        else if (unf)                  kind = (adj < MIN_NORM) ? K_SAT_ZERO : K_WRAP_UP;
        else                           kind = K_PASS;
    end

    assign exp_field = adj[FIELD_W-1:0];

endmodule

// File: rtl/rebias_pack.sv
module rebias_pack
    import rebias_pkg::*;
#(
    parameter int FIELD_W = FIELD_W_DEF,
    parameter int SIG_W   = SIG_W_DEF
) (
    input  fix_kind_e            kind,
    input  logic                 sign_in,
    input  logic [FIELD_W-1:0]   exp_in,
    input  logic [SIG_W-1:0]     sig_in,
    input  logic                 round_up,
    output logic                 sign_out,
    output logic [FIELD_W-1:0]   exp_out,
    output logic [SIG_W-1:0]     sig_out,
    output logic                 c1_out,
    output logic                 store_out
);
    localparam logic [FIELD_W-1:0] EXP_ONES = '1;
    localparam logic [SIG_W-1:0]   INF_SIG  = {1'b1, {(SIG_W-1){1'b0}}};

    always_comb begin
        store_out = kind_writes(kind);
        c1_out    = store_out ? round_up : 1'b0;
        sign_out  = store_out ? sign_in  : 1'b0;
        if (kind_keeps_sig(kind)) begin
            exp_out = exp_in;
            sig_out = sig_in;
        end else if (kind == K_SAT_INF) begin
            exp_out = EXP_ONES;
            sig_out = INF_SIG;
        end else begin
            exp_out = '0;
            sig_out = '0;
        end
    end

endmodule

// File: rtl/rebias_unit.sv
module rebias_unit
    import rebias_pkg::*;
#(
    parameter int EXP_W     = EXP_W_DEF,
    parameter int FIELD_W   = FIELD_W_DEF,
    parameter int SIG_W     = SIG_W_DEF,
    parameter int WRAP_BIAS = WRAP_BIAS_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sign,
    input  logic signed [EXP_W-1:0]  in_exp,
    input  logic [SIG_W-1:0]         in_sig,
    input  logic                     in_round_up,
    input  logic                     in_ovf,
    input  logic                     in_unf,
    input  logic                     in_dest_mem,
    output logic                     out_valid,
    output logic                     out_store,
    output logic                     out_sign,
    output logic [FIELD_W-1:0]       out_exp,
    output logic [SIG_W-1:0]         out_sig,
    output logic                     out_c1
);
    localparam logic [FIELD_W-1:0] BIAS_F   = FIELD_W'(WRAP_BIAS);
    localparam logic [FIELD_W-1:0] EXP_ONES = '1;
    localparam logic [SIG_W-1:0]   INF_SIG  = {1'b1, {(SIG_W-1){1'b0}}};

    fix_kind_e            kind;
    logic [FIELD_W-1:0]   exp_field;
    logic                 n_sign, n_c1, n_store;
    logic [FIELD_W-1:0]   n_exp;
    logic [SIG_W-1:0]     n_sig;

    rebias_classify #(
        .EXP_W(EXP_W), .FIELD_W(FIELD_W), .WRAP_BIAS(WRAP_BIAS)
    ) u_classify (
        .ovf(in_ovf), .unf(in_unf), .dest_mem(in_dest_mem),
        .exp_in(in_exp), .kind(kind), .exp_field(exp_field)
    );

    rebias_pack #(
        .FIELD_W(FIELD_W), .SIG_W(SIG_W)
    ) u_pack (
        .kind(kind), .sign_in(in_sign), .exp_in(exp_field), .sig_in(in_sig),
        .round_up(in_round_up), .sign_out(n_sign), .exp_out(n_exp),
        .sig_out(n_sig), .c1_out(n_c1), .store_out(n_store)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_store <= 1'b0;
            out_sign  <= 1'b0;
            out_exp   <= '0;
            out_sig   <= '0;
            out_c1    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_store <= in_valid & n_store;
            if (in_valid) begin
                out_sign <= n_sign;
                out_exp  <= n_exp;
                out_sig  <= n_sig;
                out_c1   <= n_c1;
            end
        end
    end

    // R9: output strobe follows the input strobe by one edge
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_store && $stable(out_exp) && $stable(out_sig)));

    // R1: wrapped-down exponent, unless saturated
    p_wrap_dn_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ovf && !in_dest_mem) |=>
        (out_store && ((out_exp == EXP_ONES) ||
                       (out_exp == $past(in_exp[FIELD_W-1:0]) - BIAS_F))));

    // R2: wrapped-up exponent, unless saturated (overflow absent)
    p_wrap_up_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_unf && !in_ovf && !in_dest_mem) |=>
        (out_store && ((out_exp == '0) ||
                       (out_exp == $past(in_exp[FIELD_W-1:0]) + BIAS_F))));

    // R3: all-ones exponent after overflow carries the infinity significand
    p_inf_sig_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ovf && !in_dest_mem) |=>
        ((out_exp != EXP_ONES) || (out_sig == INF_SIG)));

    // R4: zero exponent after underflow carries a zero significand
    p_zero_sig_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_unf && !in_ovf && !in_dest_mem) |=>
        ((out_exp != '0) || (out_sig == '0)));

    // R5: round-up bit reported for register writes
    p_c1_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dest_mem) |=> (out_c1 == $past(in_round_up)));

    // R6: memory destination with an exception writes nothing
    p_mem_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dest_mem && (in_ovf || in_unf)) |=> (!out_store && !out_c1));

endmodule

// File: tb/rebias_unit_bench.sv
module rebias_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid, in_sign, in_round_up, in_ovf, in_unf, in_dest_mem;
    logic signed [17:0] in_exp;
    logic [63:0]        in_sig;
    logic               out_valid, out_store, out_sign, out_c1;
    logic [14:0]        out_exp;
    logic [63:0]        out_sig;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    localparam logic [63:0] INF_SIG = 64'h8000_0000_0000_0000;
    localparam logic [63:0] SIG_A   = 64'hC3A5_0F0F_1234_5678;
    localparam logic [63:0] SIG_B   = 64'h8000_0000_0000_0001;

    always #(CLK_PERIOD/2) clk = ~clk;

    rebias_unit u_rebias_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_round_up(in_round_up),
        .in_ovf(in_ovf), .in_unf(in_unf), .in_dest_mem(in_dest_mem),
        .out_valid(out_valid), .out_store(out_store), .out_sign(out_sign),
        .out_exp(out_exp), .out_sig(out_sig), .out_c1(out_c1)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One input strobe; on return the registered outputs are ready to sample.
    task automatic drive(bit ovf, bit unf, bit mem, bit rup, bit sgn, int e, logic [63:0] sig);
        @(negedge clk);
        in_valid = 1'b1; in_ovf = ovf; in_unf = unf; in_dest_mem = mem;
        in_round_up = rup; in_sign = sgn; in_exp = 18'(e); in_sig = sig;
        @(negedge clk);
        in_valid = 1'b0; in_ovf = 1'b0; in_unf = 1'b0; in_dest_mem = 1'b0;
    endtask

    task automatic expect_res(string req, bit sgn, logic [14:0] e, logic [63:0] sig, bit st, bit c1);
        check(req, "valid", 64'(out_valid), 64'd1);
        check(req, "store", 64'(out_store), 64'(st));
        check(req, "sign",  64'(out_sign),  64'(sgn));
        check(req, "exp",   64'(out_exp),   64'(e));
        check(req, "sig",   out_sig,        sig);
        check(req, "c1",    64'(out_c1),    64'(c1));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_ovf = 1'b0; in_unf = 1'b0; in_dest_mem = 1'b0;
        in_round_up = 1'b0; in_sign = 1'b0; in_exp = '0; in_sig = '0;
        repeat (3) @(negedge clk);
        check("R10", "valid", 64'(out_valid), 64'd0);
        check("R10", "store", 64'(out_store), 64'd0);
        check("R10", "exp",   64'(out_exp),   64'd0);
        check("R10", "sig",   out_sig,        64'd0);
        check("R10", "c1",    64'(out_c1),    64'd0);
        rst = 1'b0;
    endtask

    task automatic t_wrap_down();   // R1
        drive(1, 0, 0, 1, 0, 40000, SIG_A);
        expect_res("R1", 0, 15'h3C40, SIG_A, 1, 1);
        drive(1, 0, 0, 0, 1, 57342, SIG_B);
        expect_res("R1", 1, 15'h7FFE, SIG_B, 1, 0);
    endtask

    task automatic t_wrap_up();     // R2
        drive(0, 1, 0, 0, 1, -10000, SIG_A);
        expect_res("R2", 1, 15'h38F0, SIG_A, 1, 0);
        drive(0, 1, 0, 1, 0, -24575, SIG_B);
        expect_res("R2", 0, 15'h0001, SIG_B, 1, 1);
    endtask

    task automatic t_massive_over(); // R3
        drive(1, 0, 0, 1, 1, 57343, SIG_A);
        expect_res("R3", 1, 15'h7FFF, INF_SIG, 1, 1);
        drive(1, 0, 0, 0, 0, 90000, SIG_B);
        expect_res("R3", 0, 15'h7FFF, INF_SIG, 1, 0);
    endtask

    task automatic t_massive_under(); // R4
        drive(0, 1, 0, 0, 1, -24576, SIG_A);
        expect_res("R4", 1, 15'h0000, 64'd0, 1, 0);
        drive(0, 1, 0, 1, 0, -60000, SIG_B);
        expect_res("R4", 0, 15'h0000, 64'd0, 1, 1);
    endtask

    task automatic t_round_bit();   // R5
        drive(0, 0, 0, 1, 0, 16383, SIG_A);
        check("R5", "c1 set", 64'(out_c1), 64'd1);
        drive(0, 0, 0, 0, 0, 16383, SIG_A);
        check("R5", "c1 clear", 64'(out_c1), 64'd0);
    endtask

    task automatic t_mem_dest();    // R6
        drive(1, 0, 1, 1, 1, 40000, SIG_A);
        check("R6", "store ovf", 64'(out_store), 64'd0);
        check("R6", "c1 ovf",    64'(out_c1),    64'd0);
        drive(0, 1, 1, 1, 0, -10000, SIG_B);
        check("R6", "store unf", 64'(out_store), 64'd0);
        check("R6", "c1 unf",    64'(out_c1),    64'd0);
    endtask

    task automatic t_pass();        // R7
        drive(0, 0, 0, 0, 1, 16383, SIG_B);
        expect_res("R7", 1, 15'h3FFF, SIG_B, 1, 0);
    endtask

    task automatic t_priority();    // R8
        drive(1, 1, 0, 0, 0, 40000, SIG_A);
        expect_res("R8", 0, 15'h3C40, SIG_A, 1, 0);
    endtask

    task automatic t_idle();        // R9
        drive(1, 0, 0, 1, 1, 40000, SIG_A);
        @(negedge clk);
        check("R9", "valid idle", 64'(out_valid), 64'd0);
        check("R9", "store idle", 64'(out_store), 64'd0);
        check("R9", "exp held",   64'(out_exp),   64'h3C40);
        check("R9", "sig held",   out_sig,        SIG_A);
        check("R9", "sign held",  64'(out_sign),  64'd1);
    endtask

    initial begin
        t_reset();
        t_wrap_down();
        t_wrap_up();
        t_massive_over();
        t_massive_under();
        t_round_bit();
        t_mem_dest();
        t_pass();
        t_priority();
        t_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule